// File: doc/BRIEF.md
# Quad-Lane SPI Word-Stream Read Slave

This block lets an external SPI master read a bank of 32-bit words held on chip. A transaction opens when chip-select falls. The master then shifts in a 24-bit start address on data line 0, followed by an 8-bit command. After that the slave streams memory words back for as long as chip-select stays low. The command sets the return path: either one bit per serial clock on data line 1, or one nibble per serial clock on all four lines. Raising chip-select at any point ends or cancels the transaction.

The serial clock, chip-select and line 0 are brought into the system clock domain with a two-flop synchronizer, and the block detects their edges there. The master's bits are taken on detected serial-clock rising edges. Returned bits change on detected falling edges, so the master can capture them on the next rising edge.

The memory sits outside the block and is reached through a plain synchronous read port with one cycle of latency. The block keeps the word pointer and advances it after each word is taken. A controller (`ST_IDLE`, `ST_ADDR`, `ST_CMD`, `ST_DATA`, `ST_HALT`) sequences the frame:
- Any state goes to `ST_IDLE` while chip-select is high.
- `ST_IDLE` goes to `ST_ADDR` when chip-select is low.
- `ST_ADDR` goes to `ST_CMD` after the 24th address bit.
- `ST_CMD` goes to `ST_DATA` on a known command, or to `ST_HALT` on any other command.

Top module: `qspi_word_reader`

## Requirements
- R1: The header is shifted in most-significant bit first on line 0, one bit per serial-clock rising edge. It is 24 address bits, then 8 command bits. The start word index is the low AW bits of the address.
- R2: Each returned word is 32 bits, most-significant first. Its first bit is on the lines before the first rising edge after the last command bit.
- R3: While chip-select stays low, words follow one another with no idle serial-clock cycle between them.
- R4: The word index advances by one after each word and wraps from 2^AW-1 to 0.
- R5: If chip-select rises before the data phase, the header is dropped. The next low period starts a fresh header.
- R6: In quad mode each nibble is placed on dq_out[3:0] with dq_out[3] as its most-significant bit. The most-significant nibble of a word goes first.
- R7: During the address and command phases every enable in dq_oe is 0, so line 0 stays an input.
- R8: Command 0x03 returns data on dq_out[1] with dq_oe = 4'b0010. Command 0x6B returns data on dq_out[3:0] with dq_oe = 4'b1111. Any other command keeps dq_oe at 0 for the rest of the frame.
- R9: Returned bits change only after serial-clock falling edges. They are steady through each high phase of the serial clock.
- R10: dq_oe is 4'b0000 whenever cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master (idles low) |
| cs_n | input | 1 | Active-low chip-select |
| d0_in | input | 1 | Master-to-slave bit on line 0 |
| dq_out | output | 4 | Slave-to-master line values |
| dq_oe | output | 4 | Per-line output enables |
| mem_addr | output | AW | Word index to the memory read port |
| mem_rdata | input | 32 | Read data, valid one clock after mem_addr |

## Verification
The single-line return is tried with an address whose upper bits are nonzero. This shows that only the low index bits select the word. The quad return is tried both mid-memory and at the last two words. The first case confirms nibble order and back-to-back streaming; the second shows wrap-around to word 0. An unknown command byte and a chip-select pulse in the middle of the address show that the lines stay released and that a cancelled header leaves no trace on the next frame. Every returned bit is sampled twice, just before the rising edge and again just before the falling edge. This separates data that changes on the wrong edge from data that is merely late.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_HALT
    } qrd_state_e;

    typedef enum logic {
        LANE_ONE,
        LANE_FOUR
    } lane_e;

    localparam logic [7:0] CMD_ONE_LINE  = 8'h03;
    localparam logic [7:0] CMD_FOUR_LINE = 8'h6B;
endpackage

// File: rtl/qspi_rd_sync.sv
module qspi_rd_sync #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_sync
);
    logic [N-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            d_sync   <= RST_VAL;
        end else begin
            stage1_q <= d_in;
            d_sync   <= stage1_q;
        end
    end
endmodule

// File: rtl/qspi_rd_txsh.sv
module qspi_rd_txsh
    import qspi_rd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step_en,
    input  lane_e         lane,
    input  logic [DW-1:0] ld_data,
    output logic [3:0]    out_bits,
    output logic          word_take,
    output logic          active
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_ONE  = CW'(DW - 1);
    localparam logic [CW-1:0] LAST_FOUR = CW'(DW / 4 - 1);

    logic [DW-1:0] sh_q;
    logic [DW-1:0] src;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        src       = (cnt_q == '0) ? ld_data : sh_q;
        last      = (lane == LANE_FOUR) ? LAST_FOUR : LAST_ONE;
        word_take = step_en && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            out_bits <= '0;
            active   <= 1'b0;
        end else if (clear) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            out_bits <= '0;
            active   <= 1'b0;
        end else if (step_en) begin
            active <= 1'b1;
            cnt_q  <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
            if (lane == LANE_FOUR) begin
                out_bits <= src[DW-1 -: 4];
                sh_q     <= src << 4;
            end else begin
                out_bits <= {2'b00, src[DW-1], 1'b0};
                sh_q     <= src << 1;
            end
        end
    end

    // R3: every word boundary in the stream lands exactly on a fresh load
    a_r3_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !clear && cnt_q == last) |=> (cnt_q == '0));
endmodule

// File: rtl/qspi_word_reader.sv
module qspi_word_reader
    import qspi_rd_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          d0_in,
    output logic [3:0]    dq_out,
    output logic [3:0]    dq_oe,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata
);
    localparam int HW = (AW - 1 > 7) ? AW - 1 : 7;
    localparam logic [4:0] ADDR_LAST = 5'd23;
    localparam logic [4:0] CMD_LAST  = 5'd7;

    logic [2:0] sync_v;
    logic       sclk_s, cs_hi_s, d0_s, sclk_q;
    logic       rise_s, fall_s;

    qspi_rd_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sclk, cs_n, d0_in}),
        .d_sync(sync_v)
    );

    assign sclk_s  = sync_v[2];
    assign cs_hi_s = sync_v[1];
    assign d0_s    = sync_v[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise_s = sclk_s & ~sclk_q;
    assign fall_s = ~sclk_s & sclk_q;

    qrd_state_e    state_q, state_d;
    logic [4:0]    cnt_q;
    logic [HW-1:0] hdr_q;
    lane_e         lane_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    cmd_full;
    logic [AW-1:0] addr_full;
    logic          cmd_known;

    logic [3:0] tx_bits;
    logic       word_take, tx_active;

    assign cmd_full  = {hdr_q[6:0], d0_s};
    assign addr_full = {hdr_q[AW-2:0], d0_s};
    assign cmd_known = (cmd_full == CMD_ONE_LINE) || (cmd_full == CMD_FOUR_LINE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_hi_s) state_d = ST_ADDR;
            ST_ADDR: begin
                if (cs_hi_s) state_d = ST_IDLE;
                else if (rise_s && cnt_q == ADDR_LAST) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (cs_hi_s) state_d = ST_IDLE;
                else if (rise_s && cnt_q == CMD_LAST)
                    state_d = cmd_known ? ST_DATA : ST_HALT;
            end
            ST_DATA: if (cs_hi_s) state_d = ST_IDLE;
            ST_HALT: if (cs_hi_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hdr_q   <= '0;
            lane_q  <= LANE_ONE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE || cs_hi_s) begin
                cnt_q <= '0;
            end else if (rise_s && (state_q == ST_ADDR || state_q == ST_CMD)) begin
                hdr_q <= {hdr_q[HW-2:0], d0_s};
                if (state_q == ST_ADDR) begin
                    cnt_q <= (cnt_q == ADDR_LAST) ? '0 : cnt_q + 1'b1;
                    if (cnt_q == ADDR_LAST) addr_q <= addr_full;
                end else begin
                    cnt_q <= (cnt_q == CMD_LAST) ? '0 : cnt_q + 1'b1;
                    if (cnt_q == CMD_LAST)
                        lane_q <= (cmd_full == CMD_FOUR_LINE) ? LANE_FOUR : LANE_ONE;
                end
            end else if (state_q == ST_DATA && word_take) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    qspi_rd_txsh #(.DW(DW)) u_txsh (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q != ST_DATA),
        .step_en  (fall_s && state_q == ST_DATA),
        .lane     (lane_q),
        .ld_data  (mem_rdata),
        .out_bits (tx_bits),
        .word_take(word_take),
        .active   (tx_active)
    );

    logic [3:0] oe_int;

    always_comb begin
        oe_int = 4'b0000;
        if (state_q == ST_DATA && tx_active)
            oe_int = (lane_q == LANE_FOUR) ? 4'b1111 : 4'b0010;
        dq_oe    = cs_n ? 4'b0000 : oe_int;
        dq_out   = tx_bits;
        mem_addr = addr_q;
    end

    // R5: a raised chip-select always returns the controller to idle
    a_r5_cancel_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi_s |=> (state_q == ST_IDLE));

    // R7: header phases never drive any line
    a_r7_hdr_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR || state_q == ST_CMD) |-> (oe_int == 4'b0000));

    // R8: an unknown command keeps the lines released
    a_r8_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (oe_int == 4'b0000));

    // R8: only the two legal enable patterns ever appear
    a_r8_oe_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_int != 4'b0000) |-> (oe_int == 4'b0010 || oe_int == 4'b1111));

    // R4: each word taken moves the pointer up by one, modulo the depth
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_take && state_q == ST_DATA) |=> (addr_q == $past(addr_q) + 1'b1));

    // R9: returned bits move only on a detected falling edge
    a_r9_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_s && state_q == ST_DATA && $past(state_q) == ST_DATA) |=> $stable(tx_bits));
endmodule

// File: tb/qspi_word_reader_tb_top.sv
module qspi_word_reader_tb_top;
    localparam int AW = 8;
    localparam int HP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic          cs_n = 1'b1;
    logic          d0_in = 1'b0;
    logic [3:0]    dq_out;
    logic [3:0]    dq_oe;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qspi_word_reader #(.AW(AW), .DW(32)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .d0_in    (d0_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memval(input logic [7:0] i);
        return {i ^ 8'h5A, ~i, i + 8'h31, 8'hC3 ^ {i[4:0], 3'b101}};
    endfunction

    always_ff @(posedge clk) mem_rdata <= memval(mem_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shift nbits of a header out on line 0; the header lines must stay released
    task automatic send_hdr(input logic [31:0] hdr, input int nbits, output int oe_bad);
        oe_bad = 0;
        for (int i = 0; i < nbits; i++) begin
            d0_in = hdr[31-i];
            repeat (HP) @(negedge clk);
            if (dq_oe !== 4'b0000) oe_bad++;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        d0_in = 1'b0;
    endtask

    task automatic get_word(input bit quad, output logic [31:0] w,
                            output int oe_bad, output int edge_bad);
        logic [3:0] a;
        int steps;
        steps = quad ? 8 : 32;
        w = '0; oe_bad = 0; edge_bad = 0;
        for (int i = 0; i < steps; i++) begin
            repeat (HP) @(negedge clk);
            a = dq_out;
            if (dq_oe !== (quad ? 4'b1111 : 4'b0010)) oe_bad++;
            w = quad ? {w[27:0], a} : {w[30:0], a[1]};
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            if (dq_out !== a) edge_bad++;
            sclk = 1'b0;
        end
    endtask

    task automatic end_frame();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R10 oe off with cs high", {28'd0, dq_oe}, 32'd0);
        repeat (10) @(negedge clk);
    endtask

    task automatic read_burst(input string tag, input logic [23:0] addr, input bit quad,
                              input int nwords, input logic [7:0] start_idx);
        logic [31:0] w;
        int ob, eb, hb;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        send_hdr({addr, quad ? 8'h6B : 8'h03}, 32, hb);
        chk({tag, " R7 header lines released"}, hb, 0);
        for (int k = 0; k < nwords; k++) begin
            get_word(quad, w, ob, eb);
            chk({tag, quad ? " R6 quad word" : " R2 word"}, w, memval(start_idx + 8'(k)));
            chk({tag, " R8 enable pattern"}, ob, 0);
            chk({tag, " R9 steady in high phase"}, eb, 0);
        end
        end_frame();
    endtask

    task automatic t_reset();
        chk("R10 reset oe", {28'd0, dq_oe}, 32'd0);
        chk("R9 reset out", {28'd0, dq_out}, 32'd0);
    endtask

    task automatic t_single();
        // R1 upper address bits ignored, R3 three back-to-back words
        read_burst("single", 24'h123405, 1'b0, 3, 8'h05);
    endtask

    task automatic t_quad();
        read_burst("quad", 24'h000010, 1'b1, 4, 8'h10);
    endtask

    task automatic t_wrap();
        // R4 index FE, FF then 00
        read_burst("wrap R4", 24'h0000FE, 1'b1, 3, 8'hFE);
    endtask

    task automatic t_unknown();
        int hb, ob;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        send_hdr({24'h000020, 8'h55}, 32, hb);
        send_hdr(32'hFFFF_FFFF, 32, ob);
        chk("R8 unknown cmd keeps lines off", ob, 0);
        end_frame();
    endtask

    task automatic t_cancel();
        int hb;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        send_hdr({24'hFFFFFF, 8'h6B}, 12, hb);
        cs_n = 1'b1;
        repeat (HP) @(negedge clk);
        chk("R5 cancelled frame oe", {28'd0, dq_oe}, 32'd0);
        repeat (10) @(negedge clk);
        read_burst("after cancel R5", 24'h000003, 1'b0, 2, 8'h03);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single();
        t_quad();
        t_wrap();
        t_unknown();
        t_cancel();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule